// File: doc/BRIEF.md
# APB3 Transaction Capture Monitor

This block sits beside an APB3 bus and listens to it. It never drives any bus signal. Each time an access phase finishes, it emits one complete record of the transfer. The record holds the direction, the address, the data that belongs to that direction, the error response and a tick stamp. Because capture waits for the exact completion condition, every record is already a whole transaction and needs no further pairing.

A record appears on the output for one clock cycle, with a valid strobe, in the cycle after the completing clock edge. A later trace buffer takes records from there and stores them. The tick stamp comes from a free-running cycle counter inside the monitor, so records can be ordered and timed against one another.

Top module: `apb_txn_monitor`

## Requirements
- R1: A record is produced for a clock edge only when select, enable and ready are all high at that edge. It appears in the following cycle with `recValid` high. Setup-phase cycles (select high, enable low) and cycles with enable high but select low produce no record.
- R2: Access cycles extended by wait states (select and enable high, ready low) produce no record.
- R3: `recWrite` equals the write signal sampled at the completing edge, where 1 means write and 0 means read.
- R4: `recData` equals the write data when the captured write signal is 1, and the read data when it is 0, both sampled at the completing edge. `recAddr` equals the address sampled at the same edge.
- R5: `recErr` is 1 (ERROR) when the slave-error signal is high at the completing edge, and 0 (OK) otherwise.
- R6: `recValid` is high for exactly one cycle per completing edge, and low in every cycle that does not follow a completing edge.
- R7: `recTick` carries the count of clock edges since reset at the completing edge. The first edge after reset release counts as 0, and the counter steps by one on every edge and wraps at its width.
- R8: Consecutive completing edges each produce their own record, even when address, data and direction do not change. Their tick stamps differ by one.
- R9: While reset is active, and in the first cycle after it, `recValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Observed peripheral select |
| busEnable | input | 1 | Observed enable (access phase) |
| busReady | input | 1 | Observed slave ready |
| busWrite | input | 1 | Observed direction, 1 = write |
| busSlvErr | input | 1 | Observed slave error |
| busAddr | input | ADDR_W | Observed address |
| busWdata | input | DATA_W | Observed write data |
| busRdata | input | DATA_W | Observed read data |
| recValid | output | 1 | One-cycle strobe for a new record |
| recWrite | output | 1 | Record direction, 1 = write |
| recAddr | output | ADDR_W | Record address |
| recData | output | DATA_W | Record data for the recorded direction |
| recErr | output | 1 | Record response, 1 = ERROR |
| recTick | output | TICK_W | Tick stamp of the completing edge |

## Verification
The in-RTL properties check, on every cycle, the link between the bus pins at one edge and the record one cycle later. They cover that a completion yields a record, that a wait state or setup cycle yields none, and that direction, address, data choice and error flag match what was sampled. They also check that the tick counter steps by one. Only the bench scenarios can show absolute tick values measured from reset release, the separation of records for identical back-to-back transfers, and mixed sequences in which reads, writes, errors and wait states are interleaved.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // access phase completes at this edge
    logic pickWrite; // data source: 1 = write data, 0 = read data
  } monStrobe_t;
endpackage

// File: rtl/apb_mon_ctrl.sv
module apb_mon_ctrl
  import apb_mon_pkg::*;
(
  input  logic       busSel,
  input  logic       busEnable,
  input  logic       busReady,
  input  logic       busWrite,
  output monStrobe_t strobes
);
  always_comb begin
    strobes.capture   = busSel & busEnable & busReady;
    strobes.pickWrite = busWrite;
  end
endmodule

// File: rtl/apb_mon_data.sv
module apb_mon_data
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strobes,
  input  logic              busSlvErr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              recValid,
  output logic              recWrite,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData,
  output logic              recErr,
  output logic [TICK_W-1:0] recTick
);
  localparam logic [TICK_W-1:0] TICK_ONE = {{(TICK_W-1){1'b0}}, 1'b1};

  logic [TICK_W-1:0] tickCnt;
  logic [DATA_W-1:0] dataSel;

  always_comb dataSel = strobes.pickWrite ? busWdata : busRdata;

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tickCnt + TICK_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) recValid <= 1'b0;
    else       recValid <= strobes.capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recWrite <= 1'b0;
      recAddr  <= '0;
      recData  <= '0;
      recErr   <= 1'b0;
      recTick  <= '0;
    end else if (strobes.capture) begin
      recWrite <= strobes.pickWrite;
      recAddr  <= busAddr;
      recData  <= dataSel;
      recErr   <= busSlvErr;
      recTick  <= tickCnt;
    end
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> tickCnt == $past(tickCnt) + TICK_ONE);                       // R7
  AST_TICK_STAMP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> recTick == $past(tickCnt));                       // R7
endmodule

// File: rtl/apb_txn_monitor.sv
module apb_txn_monitor
  import apb_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busReady,
  input  logic              busWrite,
  input  logic              busSlvErr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              recValid,
  output logic              recWrite,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData,
  output logic              recErr,
  output logic [TICK_W-1:0] recTick
);
  monStrobe_t strobes;

  apb_mon_ctrl uCtrl (
    .busSel(busSel), .busEnable(busEnable), .busReady(busReady),
    .busWrite(busWrite), .strobes(strobes)
  );

  apb_mon_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busSlvErr(busSlvErr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .recValid(recValid), .recWrite(recWrite), .recAddr(recAddr),
    .recData(recData), .recErr(recErr), .recTick(recTick)
  );

  AST_DONE_GIVES_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && busReady) |=> recValid);                      // R1
  AST_WAIT_NO_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && !busReady) |=> !recValid);                    // R2
  AST_SETUP_NO_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busEnable) |=> !recValid);                                // R6
  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && busReady) |=> recWrite == $past(busWrite));   // R3
  AST_WDATA_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && busReady && busWrite) |=> recData == $past(busWdata)); // R4
  AST_RDATA_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && busReady && !busWrite) |=> recData == $past(busRdata)); // R4
  AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busEnable && busReady) |=> recErr == $past(busSlvErr));    // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !recValid);                                                 // R9
endmodule

// File: tb/sim_apb_txn_monitor.sv
module sim_apb_txn_monitor;
  localparam int AW = 32, DW = 32, TW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busEnable = 0, busReady = 0, busWrite = 0, busSlvErr = 0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0, busRdata = '0;
  logic recValid, recWrite, recErr;
  logic [AW-1:0] recAddr;
  logic [DW-1:0] recData;
  logic [TW-1:0] recTick;

  int checks = 0, errors = 0;
  longint benchTick = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  apb_txn_monitor #(.ADDR_W(AW), .DATA_W(DW), .TICK_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busReady(busReady), .busWrite(busWrite), .busSlvErr(busSlvErr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .recValid(recValid), .recWrite(recWrite), .recAddr(recAddr),
    .recData(recData), .recErr(recErr), .recTick(recTick)
  );

  // edges since reset release; first edge counts as 0
  always @(posedge clk) if (rstN) benchTick <= benchTick + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    busSel = 0; busEnable = 0; busReady = 0; busWrite = 0; busSlvErr = 0;
  endtask

  // full transfer: setup, waits, completing access; checks every step
  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rd, input int waits, input bit err);
    longint expTick;
    busSel = 1; busEnable = 0; busReady = 1; busWrite = wr; busAddr = a;
    busWdata = wd; busRdata = rd; busSlvErr = err;
    @(posedge clk); @(negedge clk);
    check("R1 setup phase gives no record", recValid, 0);
    busEnable = 1;
    for (int i = 0; i < waits; i++) begin
      busReady = 0;
      @(posedge clk); @(negedge clk);
      check("R2 wait state gives no record", recValid, 0);
    end
    busReady = 1;
    expTick = benchTick;
    @(posedge clk); @(negedge clk);
    check("R1 completion gives record", recValid, 1);
    check("R3 direction", recWrite, wr);
    check("R4 address", recAddr, a);
    check("R4 data source", recData, wr ? wd : rd);
    check("R5 response", recErr, err);
    check("R7 tick stamp", recTick, expTick);
    idleBus();
    @(posedge clk); @(negedge clk);
    check("R6 strobe lasts one cycle", recValid, 0);
  endtask

  task automatic tReset();
    check("R9 no record in reset", recValid, 0);
    @(negedge clk); rstN = 1;
    check("R9 no record after reset", recValid, 0);
    @(posedge clk); @(negedge clk);
    check("R9 idle first cycle", recValid, 0);
  endtask

  task automatic tWriteNoWait();  xfer(1, 32'h0000_1000, 32'hDEAD_BEEF, 32'h1111_1111, 0, 0); endtask
  task automatic tReadWaits();    xfer(0, 32'h0000_2004, 32'h2222_2222, 32'hCAFE_F00D, 3, 0); endtask
  task automatic tWriteError();   xfer(1, 32'hFFFF_FFFC, 32'h0000_00A5, 32'h0, 1, 1); endtask
  task automatic tReadError();    xfer(0, 32'h8000_0000, 32'h5555_5555, 32'h7777_0000, 0, 1); endtask

  task automatic tEnableNoSel();
    busSel = 0; busEnable = 1; busReady = 1; busWrite = 1;
    @(posedge clk); @(negedge clk);
    check("R1 enable without select ignored", recValid, 0);
    idleBus();
    @(posedge clk); @(negedge clk);
    check("R6 idle no record", recValid, 0);
  endtask

  task automatic tBackToBack();
    longint t0;
    busSel = 1; busEnable = 1; busReady = 1; busWrite = 1; busSlvErr = 0;
    busAddr = 32'h40; busWdata = 32'h1234_5678;
    t0 = benchTick;
    @(posedge clk); @(negedge clk);
    check("R8 first record", recValid, 1);
    check("R8 first tick", recTick, t0);
    @(posedge clk); @(negedge clk);
    check("R8 second record", recValid, 1);
    check("R8 second tick", recTick, t0 + 1);
    check("R8 same data", recData, 32'h1234_5678);
    idleBus();
    @(posedge clk); @(negedge clk);
    check("R6 strobe ends", recValid, 0);
  endtask

  initial begin
    tReset();
    tWriteNoWait();
    tReadWaits();
    tWriteError();
    tReadError();
    tEnableNoSel();
    tBackToBack();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule